// File: doc/BRIEF.md
# Colour Lookup Table with Byte-Serial Host Access

This block holds a colour lookup table of 256 entries, each an 8-bit red, an 8-bit green and an 8-bit blue value. A host reaches the table through four small registers. It first loads a write pointer and then streams colour bytes through a single data register. A modulo-3 phase counter sends each byte to the red, green or blue plane in turn, and the pointer moves to the next entry after the blue byte.

Reading back works the same way, through its own pointer and its own phase counter. This lets a readback run without disturbing a write sequence that is in progress, and the other way round.

A pixel-side port runs every cycle without any handshake. It masks an incoming index with a programmable mask and returns the 24-bit colour of that entry on the next clock. Host writes never stall this port.

Top module: `clut_top`

## Requirements
- R1: After reset the write pointer, the read pointer and both phase counters are 0, the pixel mask is 0xFF, and `hostRdata` and `pixColor` are 0.
- R2: A host write to register 0 loads the write pointer and resets the write phase to red. Each host write to register 1 stores the byte into red, then green, then blue of the entry at the write pointer. The write pointer increments by one after the blue byte.
- R3: After 768 consecutive data writes that start from write pointer 0, the write pointer has wrapped back to 0, and reading register 0 returns 0.
- R4: A host write to register 2 loads the read pointer and resets the read phase. Successive host reads of register 1 return red, green and blue of that entry, and the read pointer increments by one after the blue byte.
- R5: The write and read sequences keep separate phase counters and pointers. Data writes leave the read phase and read pointer unchanged, and data reads leave the write phase and write pointer unchanged.
- R6: A data read returns the entry selected by the read pointer, not the one selected by the write pointer.
- R7: For a pixel index `i` presented in cycle t, `pixColor` in cycle t+1 equals the entry at `(i AND mask)`. The layout is red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The mask is loaded by a host write to register 3.
- R8: With a mask of 0xFF the pixel index is used unchanged.
- R9: `hostRdata` is registered and is updated one cycle after a cycle with `hostRd` high. The registers read as follows: register 0 gives the write pointer, register 1 gives the data byte, register 2 gives the read pointer and register 3 gives the mask. `hostRdata` holds its value in cycles without a read.
- R10: The pixel port returns a result every cycle, including cycles in which the host is writing the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostSel | input | 2 | Register select: 0 write pointer, 1 data, 2 read pointer, 3 mask |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Registered host read byte |
| pixIdx | input | 8 | Pixel index |
| pixColor | output | 24 | Colour of the masked index, one cycle later |

## Verification
The bench builds the block with its default parameters: an 8-bit index and 8-bit colour planes. With these values a full 768-byte fill is short enough to reach the pointer wrap back to 0 and the phase continuity across every entry boundary. An 8-bit mask also makes it possible to alias high pixel indices onto low entries and to check that 0xFF passes every index through unchanged.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    SEL_WPTR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_RPTR = 2'd2,
    SEL_MASK = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  localparam int NUM_PLANES = 3;

  typedef struct packed {
    logic [NUM_PLANES-1:0] writePlane;
    logic                  wrPtrLoad;
    logic                  wrPtrStep;
    logic                  rdPtrLoad;
    logic                  rdPtrStep;
    logic                  maskLoad;
    phase_e                rdPlane;
  } clutStrobes_t;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [1:0]         hostSel,
  input  logic [IDX_W-1:0]   wrPtr,
  input  logic [IDX_W-1:0]   rdPtr,
  input  logic [IDX_W-1:0]   mask,
  input  logic [COLOR_W-1:0] rdByte,
  output clutStrobes_t       strobes,
  output logic [COLOR_W-1:0] hostRdata
);

  regSel_e sel;
  phase_e  wrPhase, rdPhase;
  logic    wrData, rdData;

  assign sel    = regSel_e'(hostSel);
  assign wrData = hostWr && (sel == SEL_DATA);
  assign rdData = hostRd && (sel == SEL_DATA);

  function automatic phase_e nextPhase(input phase_e ph);
    case (ph)
      PH_RED:   return PH_GREEN;
      PH_GREEN: return PH_BLUE;
      default:  return PH_RED;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPhase <= PH_RED;
    end else if (hostWr && (sel == SEL_WPTR)) begin
      wrPhase <= PH_RED;
    end else if (wrData) begin
      wrPhase <= nextPhase(wrPhase);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPhase <= PH_RED;
    end else if (hostWr && (sel == SEL_RPTR)) begin
      rdPhase <= PH_RED;
    end else if (rdData) begin
      rdPhase <= nextPhase(rdPhase);
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.writePlane = wrData ? (NUM_PLANES'(1) << wrPhase) : '0;
    strobes.wrPtrLoad  = hostWr && (sel == SEL_WPTR);
    strobes.wrPtrStep  = wrData && (wrPhase == PH_BLUE);
    strobes.rdPtrLoad  = hostWr && (sel == SEL_RPTR);
    strobes.rdPtrStep  = rdData && (rdPhase == PH_BLUE);
    strobes.maskLoad   = hostWr && (sel == SEL_MASK);
    strobes.rdPlane    = rdPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (hostRd) begin
      case (sel)
        SEL_WPTR: hostRdata <= COLOR_W'(wrPtr);
        SEL_DATA: hostRdata <= rdByte;
        SEL_RPTR: hostRdata <= COLOR_W'(rdPtr);
        default:  hostRdata <= COLOR_W'(mask);
      endcase
    end
  end

endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  clutStrobes_t                  strobes,
  input  logic [COLOR_W-1:0]            hostWdata,
  input  logic [IDX_W-1:0]              pixIdx,
  output logic [IDX_W-1:0]              wrPtr,
  output logic [IDX_W-1:0]              rdPtr,
  output logic [IDX_W-1:0]              mask,
  output logic [COLOR_W-1:0]            rdByte,
  output logic [NUM_PLANES*COLOR_W-1:0] pixColor
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]              lookupIdx;
  logic [NUM_PLANES*COLOR_W-1:0] rdCand;

  assign lookupIdx = pixIdx & mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobes.wrPtrLoad) begin
      wrPtr <= hostWdata[IDX_W-1:0];
    end else if (strobes.wrPtrStep) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (strobes.rdPtrLoad) begin
      rdPtr <= hostWdata[IDX_W-1:0];
    end else if (strobes.rdPtrStep) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask <= '1;
    end else if (strobes.maskLoad) begin
      mask <= hostWdata[IDX_W-1:0];
    end
  end

  // One storage plane per colour; plane 0 is red and is placed in the top byte.
  for (genvar p = 0; p < NUM_PLANES; p++) begin : gPlane
    logic [COLOR_W-1:0] store [ENTRIES];
    logic [COLOR_W-1:0] pixQ;

    always_ff @(posedge clk) begin
      if (strobes.writePlane[p]) begin
        store[wrPtr] <= hostWdata;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pixQ <= '0;
      end else begin
        pixQ <= store[lookupIdx];
      end
    end

    assign rdCand[p*COLOR_W +: COLOR_W] = store[rdPtr];
    assign pixColor[(NUM_PLANES-1-p)*COLOR_W +: COLOR_W] = pixQ;
  end

  always_comb begin
    case (strobes.rdPlane)
      PH_RED:   rdByte = rdCand[0*COLOR_W +: COLOR_W];
      PH_GREEN: rdByte = rdCand[1*COLOR_W +: COLOR_W];
      default:  rdByte = rdCand[2*COLOR_W +: COLOR_W];
    endcase
  end

endmodule

// File: rtl/clut_top.sv
module clut_top
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hostWr,
  input  logic                          hostRd,
  input  logic [1:0]                    hostSel,
  input  logic [COLOR_W-1:0]            hostWdata,
  output logic [COLOR_W-1:0]            hostRdata,
  input  logic [IDX_W-1:0]              pixIdx,
  output logic [NUM_PLANES*COLOR_W-1:0] pixColor
);

  clutStrobes_t       strobes;
  logic [IDX_W-1:0]   wrPtr, rdPtr, mask;
  logic [COLOR_W-1:0] rdByte;

  clut_ctrl #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .hostSel  (hostSel),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .mask     (mask),
    .rdByte   (rdByte),
    .strobes  (strobes),
    .hostRdata(hostRdata)
  );

  clut_datapath #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .hostWdata(hostWdata),
    .pixIdx   (pixIdx),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .mask     (mask),
    .rdByte   (rdByte),
    .pixColor (pixColor)
  );

endmodule

// File: rtl/clut_checker.sv
module clut_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWr,
  input logic             hostRd,
  input logic [1:0]       hostSel,
  input logic [2:0]       writePlane,
  input logic             rdStep,
  input logic [IDX_W-1:0] wrPtr,
  input logic [IDX_W-1:0] rdPtr
);

  // R2: at most one colour plane is written per cycle
  assert_one_plane_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(writePlane));

  // R2: the first data write after a pointer load goes to red
  assert_load_then_red_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hostWr && hostSel == 2'd0) && hostWr && hostSel == 2'd1) |-> writePlane == 3'b001);

  // R2: the blue write moves the write pointer on by one
  assert_blue_advances_R2: assert property (@(posedge clk) disable iff (!rstN)
    writePlane[2] |=> wrPtr == IDX_W'($past(wrPtr) + 1'b1));

  // R4: the third read of an entry moves the read pointer on by one
  assert_read_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStep && !(hostWr && hostSel == 2'd2)) |=> rdPtr == IDX_W'($past(rdPtr) + 1'b1));

  // R5: data writes leave the read pointer alone
  assert_write_keeps_rdptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostSel == 2'd1 && !hostRd) |=> $stable(rdPtr));

  // R5: data reads leave the write pointer alone
  assert_read_keeps_wrptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr) |=> $stable(wrPtr));

endmodule

bind clut_top clut_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostSel   (hostSel),
  .writePlane(strobes.writePlane),
  .rdStep    (strobes.rdPtrStep),
  .wrPtr     (wrPtr),
  .rdPtr     (rdPtr)
);

// File: tb/clut_top_tb.sv
module clut_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [7:0]  hostWdata = 8'd0, pixIdx = 8'd0;
  logic [7:0]  hostRdata;
  logic [23:0] pixColor;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int   mem [3][256];
  bit   known [3][256];
  int   mWp = 0, mWph = 0, mRp = 0, mRph = 0, mMask = 255;

  always #2 clk = ~clk;

  clut_top u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .pixIdx(pixIdx), .pixColor(pixColor)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge,
  // compare just after it.
  task automatic step(input bit wr, input bit rd, input int sel, input int wd,
                      input int pix, input string tag);
    int  li, expPix, expRd;
    bit  pixOk, rdOk;
    hostWr = wr; hostRd = rd; hostSel = 2'(sel); hostWdata = 8'(wd); pixIdx = 8'(pix);
    li     = pix & mMask;
    pixOk  = known[0][li] && known[1][li] && known[2][li];
    expPix = (mem[0][li] << 16) | (mem[1][li] << 8) | mem[2][li];
    rdOk   = 1'b1;
    expRd  = 0;
    case (sel)
      0: expRd = mWp;
      1: begin expRd = mem[mRph][mRp]; rdOk = known[mRph][mRp]; end
      2: expRd = mRp;
      default: expRd = mMask;
    endcase
    @(posedge clk);
    if (wr) begin
      case (sel)
        0: begin mWp = wd; mWph = 0; end
        1: begin
             mem[mWph][mWp] = wd; known[mWph][mWp] = 1'b1;
             if (mWph == 2) begin mWph = 0; mWp = (mWp + 1) % 256; end
             else mWph++;
           end
        2: begin mRp = wd; mRph = 0; end
        default: mMask = wd;
      endcase
    end
    if (rd && sel == 1) begin
      if (mRph == 2) begin mRph = 0; mRp = (mRp + 1) % 256; end
      else mRph++;
    end
    #1;
    if (pixOk) check({tag, " pixel"}, int'(pixColor), expPix);
    if (rd && rdOk) check({tag, " host read"}, int'(hostRdata), expRd);
    @(negedge clk);
  endtask

  function automatic int pattern(input int e, input int c);
    return (e * 7 + c * 85 + 3) & 255;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 256; e++) begin mem[c][e] = 0; known[c][e] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 reset hostRdata", int'(hostRdata), 0);
    check("R1 reset pixColor", int'(pixColor), 0);
    rstN = 1'b1;
    @(negedge clk);
    step(0, 1, 0, 0, 0, "R1 write pointer");
    step(0, 1, 2, 0, 0, "R1 read pointer");
    step(0, 1, 3, 0, 0, "R1 mask");
    step(0, 0, 0, 0, 0, "R9 hold");
    check("R9 hostRdata holds without read", int'(hostRdata), 255);

    // full fill while the pixel port sweeps
    step(1, 0, 0, 0, 0, "R2 load");
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++)
        step(1, 0, 1, pattern(e, c), (e * 3 + c + 200) & 255, "R10");
    step(0, 1, 0, 0, 0, "R3 wrap");
    check("R3 write pointer wrapped", int'(hostRdata), 0);

    // reload mid-entry: phase must restart at red
    step(1, 0, 0, 10, 0, "R2");
    step(1, 0, 1, 8'hA1, 0, "R2");
    step(1, 0, 1, 8'hA2, 0, "R2");
    step(1, 0, 0, 20, 0, "R2");
    step(1, 0, 1, 8'hB1, 0, "R2");
    step(1, 0, 1, 8'hB2, 0, "R2");
    step(1, 0, 1, 8'hB3, 0, "R2");
    step(0, 1, 0, 0, 20, "R2 pointer after blue");
    check("R2 write pointer advanced", int'(hostRdata), 21);
    step(0, 0, 0, 0, 20, "R7");
    check("R2 entry 20 colour", int'(pixColor), 24'hB1B2B3);
    step(0, 0, 0, 0, 10, "R7");
    check("R2 entry 10 colour", int'(pixColor), (8'hA1 << 16) | (8'hA2 << 8) | pattern(10, 2));

    // readback
    step(1, 0, 2, 20, 0, "R4");
    step(0, 1, 1, 0, 0, "R4");
    check("R4 red", int'(hostRdata), 8'hB1);
    step(0, 1, 1, 0, 0, "R4");
    step(0, 1, 1, 0, 0, "R4");
    check("R4 blue", int'(hostRdata), 8'hB3);
    step(0, 1, 2, 0, 0, "R4");
    check("R4 read pointer advanced", int'(hostRdata), 21);
    step(1, 0, 2, 7, 0, "R4");
    step(0, 1, 1, 0, 0, "R4");
    step(1, 0, 2, 7, 0, "R4 reload");
    step(0, 1, 1, 0, 0, "R4 reload");
    check("R4 reload restarts at red", int'(hostRdata), pattern(7, 0));

    // interleaved read and write sequences
    step(1, 0, 0, 100, 0, "R5");
    step(1, 0, 2, 5, 0, "R6");
    for (int k = 0; k < 6; k++) begin
      step(0, 1, 1, 0, 0, "R6");
      step(1, 0, 1, 8'h40 + k, 0, "R5");
    end
    step(0, 1, 0, 0, 0, "R5");
    check("R5 write pointer", int'(hostRdata), 102);
    step(0, 1, 2, 0, 0, "R5");
    check("R5 read pointer", int'(hostRdata), 7);
    step(0, 0, 0, 0, 101, "R5");
    check("R5 entry 101", int'(pixColor), 24'h434445);

    // mask
    step(1, 0, 3, 8'h0F, 8'hF3, "R7");
    step(0, 0, 0, 0, 8'hF3, "R7 masked");
    check("R7 masked index 0xF3 -> 3", int'(pixColor),
          (pattern(3, 0) << 16) | (pattern(3, 1) << 8) | pattern(3, 2));
    step(1, 0, 3, 8'hFF, 8'hF3, "R8");
    step(0, 0, 0, 0, 8'hF3, "R8 unmasked");
    check("R8 unmasked index 0xF3", int'(pixColor),
          (pattern(243, 0) << 16) | (pattern(243, 1) << 8) | pattern(243, 2));
    step(1, 0, 3, 8'hA5, 0, "R7");
    for (int k = 0; k < 300; k++)
      step(0, (k % 5) == 0, k % 4, 0, $urandom & 255, "R7");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule